// File: doc/BRIEF.md
# Bridge I/O Window Decoder

This block keeps the I/O window configuration of a bus bridge and, for each I/O transaction presented to it, decides whether the bridge forwards the transaction or answers it with a master abort. A configuration port with dword-aligned byte addresses, byte enables, write data and combinational read data reaches the command byte, the window base and limit bytes, the reserved upper-half registers and a granularity-select bit. A request port takes a 16-bit I/O address and a direction flag, and returns a registered decision one clock later.

The window covers the inclusive range from a decoded base address to a decoded limit address. Software can switch the window between two granularities at any time. In coarse mode the window is aligned to 4 KB. In fine mode it is aligned to 1 KB. The stored register bits stay as they are when the mode changes, and the block reads them under the new layout. Transactions coming in from the secondary side are never forwarded.

Top module: `iowin_decoder`

## Requirements
- R1: An outbound request (req_inbound = 0) gets rsp_fwd = 1 only when the command byte at offset 04h has bit 0 (I/O enable) set and base <= req_addr <= limit. Every other outbound request gets rsp_fwd = 0, which means master abort.
- R2: Every inbound request (req_inbound = 1) gets rsp_fwd = 0, whatever the registers hold.
- R3: If the decoded base is above the decoded limit, the window is off and nothing is forwarded, even with I/O enable set.
- R4: Coarse mode (granularity bit clear). In the dword at 1Ch, byte 0 is the base byte and byte 1 is the limit byte. Bits [7:4] of each give address bits [15:12]. The implied low bits are 000h for the base and FFFh for the limit. Bits [3:0] of both bytes read as 0.
- R5: Bit 0 of the byte at offset 40h selects fine mode. In fine mode, bits [7:2] of the base and limit bytes give address bits [15:10]. Bits [1:0] read as 0. The implied low bits are 000h for the base and 3FFh for the limit.
- R6: The 32-bit dword at 30h holds the reserved upper base half (30h) and the reserved upper limit half (32h). It reads as zero, and writes to it change nothing.
- R7: After reset the decoded base is 0000h and the decoded limit is 0FFFh. The command byte, the granularity bit and rsp_valid are all 0.
- R8: Bit 2 of the command byte (master enable) reads back as written and has no effect on any decision.
- R9: In coarse mode, a write to a base or limit byte leaves stored bits [3:2] unchanged. When the block returns to fine mode, those bits read back and decode as they were stored before.
- R10: rsp_valid follows req_valid with one clock of delay. A configuration write governs requests issued from the next cycle onward.
- R11: A configuration write changes only the bytes whose byte enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address (dword aligned) |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr, combinational |
| req_valid | input | 1 | I/O request present |
| req_addr | input | 16 | I/O address of the request |
| req_inbound | input | 1 | 1 = inbound, 0 = outbound |
| rsp_valid | output | 1 | Decision valid, one cycle after req_valid |
| rsp_fwd | output | 1 | 1 = forward, 0 = master abort |

## Verification
The bench builds the block with its default parameters. These give a 16-bit I/O space and an 8-bit configuration address, so every register setting is small enough to enumerate. Every base and limit pair is swept in both modes: 256 pairs in coarse mode and 4096 in fine mode. Each pair is probed at both window edges, just outside each edge and at the midpoint. The sweep therefore covers the disabled window with base above limit, the 64 KB full window and wrap-around probe addresses. Directed sequences cover reset values, byte enables, the reserved dword, the master enable bit and bit preservation across mode changes.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

    localparam int IO_AW      = 16;
    localparam int CFG_DW     = 32;
    localparam int CFG_BE_W   = CFG_DW / 8;
    localparam int FINE_LSB   = 10;
    localparam int COARSE_LSB = 12;
    localparam int FIELD_W    = IO_AW - FINE_LSB;

    typedef logic [IO_AW-1:0]   io_addr_t;
    typedef logic [FIELD_W-1:0] win_field_t;

    typedef enum logic {
        DIR_OUTBOUND = 1'b0,
        DIR_INBOUND  = 1'b1
    } io_dir_e;

    typedef struct packed {
        logic       io_en;
        logic       mst_en;
        logic       fine;
        win_field_t base_f;
        win_field_t lim_f;
    } cfg_state_t;

    typedef struct packed {
        io_addr_t lo;
        io_addr_t hi;
        logic     on;
    } window_t;

    typedef struct packed {
        logic     valid;
        io_addr_t addr;
        io_dir_e  dir;
    } io_req_t;

    typedef struct packed {
        logic valid;
        logic fwd;
    } io_rsp_t;

    // Writable part of a field depends on the granularity in force.
    function automatic win_field_t merge_field(win_field_t old_f, win_field_t new_f, logic fine);
        win_field_t r;
        r = new_f;
        if (!fine) r[COARSE_LSB-FINE_LSB-1:0] = old_f[COARSE_LSB-FINE_LSB-1:0];
        return r;
    endfunction

    // Byte image of a field as software sees it.
    function automatic logic [7:0] view_field(win_field_t f, logic fine);
        logic [7:0] b;
        b = {f, 2'b00};
        if (!fine) b[3:0] = 4'h0;
        return b;
    endfunction

    function automatic io_addr_t expand_lo(win_field_t f, logic fine);
        io_addr_t a;
        a = '0;
        a[IO_AW-1:FINE_LSB] = f;
        if (!fine) a[COARSE_LSB-1:0] = '0;
        return a;
    endfunction

    function automatic io_addr_t expand_hi(win_field_t f, logic fine);
        io_addr_t a;
        a = '1;
        a[IO_AW-1:FINE_LSB] = f;
        if (!fine) a[COARSE_LSB-1:0] = '1;
        return a;
    endfunction

endpackage

// File: rtl/iowin_cfg_regs.sv
module iowin_cfg_regs
    import iowin_pkg::*;
#(
    parameter int          CFG_AW   = 8,
    parameter int unsigned OFF_CMD  = 'h04,
    parameter int unsigned OFF_WIN  = 'h1C,
    parameter int unsigned OFF_RSV  = 'h30,
    parameter int unsigned OFF_GRAN = 'h40
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wr,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [CFG_BE_W-1:0] cfg_be,
    input  logic [CFG_DW-1:0]   cfg_wdata,
    output logic [CFG_DW-1:0]   cfg_rdata,
    output cfg_state_t          st
);
    localparam int WORD_LSB = $clog2(CFG_BE_W);
    localparam int DW_AW    = CFG_AW - WORD_LSB;
    localparam logic [DW_AW-1:0] A_CMD  = DW_AW'(OFF_CMD  >> WORD_LSB);
    localparam logic [DW_AW-1:0] A_WIN  = DW_AW'(OFF_WIN  >> WORD_LSB);
    localparam logic [DW_AW-1:0] A_RSV  = DW_AW'(OFF_RSV  >> WORD_LSB);
    localparam logic [DW_AW-1:0] A_GRAN = DW_AW'(OFF_GRAN >> WORD_LSB);

    logic [DW_AW-1:0] dw;
    logic hit_cmd, hit_win, hit_gran;

    assign dw       = cfg_addr[CFG_AW-1:WORD_LSB];
    assign hit_cmd  = (dw == A_CMD);
    assign hit_win  = (dw == A_WIN);
    assign hit_gran = (dw == A_GRAN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (cfg_wr) begin
            if (hit_cmd && cfg_be[0]) begin
                st.io_en  <= cfg_wdata[0];
                st.mst_en <= cfg_wdata[2];
            end
            if (hit_gran && cfg_be[0]) st.fine <= cfg_wdata[0];
            if (hit_win && cfg_be[0]) st.base_f <= merge_field(st.base_f, cfg_wdata[7:2], st.fine);
            if (hit_win && cfg_be[1]) st.lim_f  <= merge_field(st.lim_f, cfg_wdata[15:10], st.fine);
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (hit_cmd) begin
            cfg_rdata[0] = st.io_en;
            cfg_rdata[2] = st.mst_en;
        end
        if (hit_gran) cfg_rdata[0] = st.fine;
        if (hit_win) begin
            cfg_rdata[7:0]  = view_field(st.base_f, st.fine);
            cfg_rdata[15:8] = view_field(st.lim_f, st.fine);
        end
    end

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{cfg_addr[WORD_LSB-1:0], cfg_wdata[31:16], cfg_wdata[9:8],
                               cfg_wdata[1], cfg_be[CFG_BE_W-1:2]};

    assert_rsv_reads_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (dw == A_RSV) |-> (cfg_rdata == '0));

    assert_coarse_low_bits_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (hit_win && !st.fine) |-> (cfg_rdata[3:0] == 4'h0 && cfg_rdata[11:8] == 4'h0));

    assert_coarse_keeps_fine_bits_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && hit_win && cfg_be[0] && !st.fine) |=> (st.base_f[1:0] == $past(st.base_f[1:0])));

endmodule

// File: rtl/iowin_window_map.sv
module iowin_window_map
    import iowin_pkg::*;
(
    input  win_field_t base_f,
    input  win_field_t lim_f,
    input  logic       fine,
    output window_t    win
);
    always_comb begin
        win.lo = expand_lo(base_f, fine);
        win.hi = expand_hi(lim_f, fine);
        win.on = (win.lo <= win.hi);
    end
endmodule

// File: rtl/iowin_decide.sv
module iowin_decide
    import iowin_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  io_req_t req,
    input  window_t win,
    input  logic    io_en,
    output io_rsp_t rsp
);
    logic in_range;
    assign in_range = (req.addr >= win.lo) && (req.addr <= win.hi);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp <= '0;
        end else begin
            rsp.valid <= req.valid;
            rsp.fwd   <= req.valid && (req.dir == DIR_OUTBOUND) && io_en && win.on && in_range;
        end
    end

    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
        req.valid |=> rsp.valid);

    assert_idle_follows_R10: assert property (@(posedge clk) disable iff (rst)
        !req.valid |=> !rsp.valid && !rsp.fwd);

    assert_inbound_abort_R2: assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.dir == DIR_INBOUND) |=> !rsp.fwd);

    assert_disabled_abort_R1: assert property (@(posedge clk) disable iff (rst)
        (req.valid && !io_en) |=> !rsp.fwd);

    assert_window_off_R3: assert property (@(posedge clk) disable iff (rst)
        (req.valid && !win.on) |=> !rsp.fwd);

endmodule

// File: rtl/iowin_decoder.sv
module iowin_decoder
    import iowin_pkg::*;
#(
    parameter int          CFG_AW   = 8,
    parameter int unsigned OFF_CMD  = 'h04,
    parameter int unsigned OFF_WIN  = 'h1C,
    parameter int unsigned OFF_RSV  = 'h30,
    parameter int unsigned OFF_GRAN = 'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              req_valid,
    input  logic [15:0]       req_addr,
    input  logic              req_inbound,
    output logic              rsp_valid,
    output logic              rsp_fwd
);
    cfg_state_t st;
    window_t    win;
    io_req_t    req;
    io_rsp_t    rsp;

    iowin_cfg_regs #(
        .CFG_AW(CFG_AW), .OFF_CMD(OFF_CMD), .OFF_WIN(OFF_WIN),
        .OFF_RSV(OFF_RSV), .OFF_GRAN(OFF_GRAN)
    ) regs_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .st(st)
    );

    iowin_window_map map_i (
        .base_f(st.base_f), .lim_f(st.lim_f), .fine(st.fine), .win(win)
    );

    always_comb begin
        req.valid = req_valid;
        req.addr  = req_addr;
        req.dir   = req_inbound ? DIR_INBOUND : DIR_OUTBOUND;
    end

    iowin_decide dec_i (
        .clk(clk), .rst(rst), .req(req), .win(win), .io_en(st.io_en), .rsp(rsp)
    );

    assign rsp_valid = rsp.valid;
    assign rsp_fwd   = rsp.fwd;

endmodule

// File: tb/iowin_decoder_tb.sv
module iowin_decoder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_inbound = 1'b0;
    logic        rsp_valid, rsp_fwd;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench model of the register contents, kept per the requirements.
    bit       m_io, m_mst, m_fine;
    bit [5:0] m_base, m_lim;

    always #(CLK_PERIOD/2) clk = ~clk;

    iowin_decoder dut_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_addr(req_addr), .req_inbound(req_inbound), .rsp_valid(rsp_valid), .rsp_fwd(rsp_fwd)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int exp_lo();
        return m_fine ? int'(m_base) * 1024 : int'(m_base >> 2) * 4096;
    endfunction

    function automatic int exp_hi();
        return m_fine ? int'(m_lim) * 1024 + 1023 : int'(m_lim >> 2) * 4096 + 4095;
    endfunction

    function automatic logic [7:0] exp_byte(bit [5:0] f);
        return m_fine ? {f, 2'b00} : {f[5:2], 4'h0};
    endfunction

    function automatic logic [31:0] exp_rd(logic [7:0] a);
        case (a & 8'hFC)
            8'h04: return {29'd0, m_mst, 1'b0, m_io};
            8'h1C: return {16'd0, exp_byte(m_lim), exp_byte(m_base)};
            8'h40: return {31'd0, m_fine};
            default: return 32'd0;
        endcase
    endfunction

    task automatic cfg_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 0;
        case (a & 8'hFC)
            8'h04: if (be[0]) begin m_io = d[0]; m_mst = d[2]; end
            8'h40: if (be[0]) m_fine = d[0];
            8'h1C: begin
                if (be[0]) m_base = m_fine ? d[7:2] : {d[7:4], m_base[1:0]};
                if (be[1]) m_lim  = m_fine ? d[15:10] : {d[15:12], m_lim[1:0]};
            end
            default: ;
        endcase
    endtask

    task automatic cfg_check(input string tag, input logic [7:0] a);
        cfg_addr = a;
        #1;
        check(tag, cfg_rdata, exp_rd(a));
    endtask

    task automatic do_req(input string tag, input int addr, input bit inb);
        bit e;
        int a16;
        a16 = addr & 16'hFFFF;
        e = !inb && m_io && (exp_lo() <= exp_hi()) && (a16 >= exp_lo()) && (a16 <= exp_hi());
        @(negedge clk);
        req_valid = 1; req_addr = a16[15:0]; req_inbound = inb;
        @(negedge clk);
        check({tag, " R10 valid"}, {31'd0, rsp_valid}, 32'd1);
        check(tag, {31'd0, rsp_fwd}, {31'd0, e});
        req_valid = 0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R7: reset state
        check("R7 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        cfg_check("R7 cmd", 8'h04);
        cfg_check("R7 window", 8'h1C);
        cfg_check("R7 gran", 8'h40);
        do_req("R1 io disabled", 16'h0000, 0);
        cfg_write(8'h04, 4'h1, 32'h1);
        do_req("R7 limit 0FFF inside", 16'h0FFF, 0);
        do_req("R7 limit 0FFF outside", 16'h1000, 0);
        @(negedge clk);
        check("R10 idle", {31'd0, rsp_valid}, 32'd0);

        // R8: master enable reads back, no effect
        cfg_write(8'h04, 4'h1, 32'h5);
        cfg_check("R8 readback", 8'h04);
        do_req("R8 fwd with mst", 16'h0800, 0);
        cfg_write(8'h04, 4'h1, 32'h1);
        do_req("R8 fwd without mst", 16'h0800, 0);
        cfg_write(8'h04, 4'h1, 32'h4);
        cfg_check("R8 readback 2", 8'h04);
        do_req("R1 mst only aborts", 16'h0800, 0);
        cfg_write(8'h04, 4'h1, 32'h1);

        // R11: byte enables
        cfg_write(8'h1C, 4'h3, 32'h0000_5020);
        cfg_write(8'h1C, 4'h2, 32'hFFFF_F0F0);
        cfg_check("R11 limit byte only", 8'h1C);
        cfg_write(8'h1C, 4'h1, 32'hFFFF_0010);
        cfg_check("R11 base byte only", 8'h1C);
        cfg_write(8'h04, 4'h2, 32'h0000_0000);
        cfg_check("R11 cmd untouched", 8'h04);

        // R6: reserved dword
        cfg_write(8'h30, 4'hF, 32'hFFFF_FFFF);
        cfg_write(8'h32, 4'hF, 32'hFFFF_FFFF);
        cfg_check("R6 upper base", 8'h30);
        cfg_check("R6 upper limit", 8'h32);
        cfg_check("R6 window intact", 8'h1C);
        do_req("R6 decode intact", 16'h1000, 0);

        // R9: preservation across modes
        cfg_write(8'h40, 4'h1, 32'h1);
        cfg_write(8'h1C, 4'h3, 32'h0000_3C2C);
        cfg_check("R9 fine view", 8'h1C);
        cfg_write(8'h40, 4'h1, 32'h0);
        cfg_check("R9 coarse view", 8'h1C);
        do_req("R9 coarse lo", 16'h2000, 0);
        cfg_write(8'h1C, 4'h3, 32'h0000_4030);
        cfg_write(8'h40, 4'h1, 32'h1);
        cfg_check("R9 bits kept", 8'h1C);
        do_req("R9 fine lo edge", 16'h3C00, 0);
        do_req("R9 fine below", 16'h3BFF, 0);
        cfg_write(8'h40, 4'h1, 32'h0);

        // R1 R3 R4 R5 R2: sweep of every base/limit pair in both modes
        for (int g = 0; g < 2; g++) begin
            cfg_write(8'h40, 4'h1, g);
            for (int b = 0; b < (g ? 64 : 16); b++) begin
                for (int l = 0; l < (g ? 64 : 16); l++) begin
                    logic [7:0] bb, lb;
                    int lo, hi;
                    bb = g ? 8'(b << 2) : 8'(b << 4);
                    lb = g ? 8'(l << 2) : 8'(l << 4);
                    cfg_write(8'h1C, 4'h3, {16'd0, lb, bb});
                    lo = exp_lo();
                    hi = exp_hi();
                    if (b == l) cfg_check(g ? "R5 layout" : "R4 layout", 8'h1C);
                    do_req(g ? "R5 base edge R1" : "R4 base edge R1", lo, 0);
                    do_req(g ? "R5 limit edge R1" : "R4 limit edge R1", hi, 0);
                    do_req("R3 R1 below base", lo - 1, 0);
                    do_req("R3 R1 above limit", hi + 1, 0);
                    do_req("R1 midpoint", (lo + hi) / 2, 0);
                    do_req("R2 inbound", lo, 1);
                end
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule